// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through non-inverting paths and keeps one holding register for each direction. The bus is cut into independent lanes (two lanes of eight bits by default). Each lane has its own isolate control, direction control, two capture enables and two source selects. Tying the controls of all lanes together gives full-width operation.

Each bus has separate input, output and per-lane drive-enable signals. A higher level can map them onto tristate pins. The lane drives its target bus with either live data from the opposite bus or the value held in that direction's register. The registers capture on every clock edge where their capture enable is high. This happens whatever the isolate and direction settings are, so data can be stored while a lane is isolated or while it drives the other way.

All sequential logic runs on one clock. A capture enable sampled high at a rising edge stands in for a rising edge of a dedicated capture clock. A parameter selects an asynchronous or a synchronous active-low reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both holding registers of every lane clear to zero. After reset, a stored-mode output reads zero until new data is captured.
- R2: At a rising clock edge where `grab_a` of lane L is 1, the A-side register of lane L loads `a_in` bits [8L+7:8L]. This happens regardless of `lane_iso`, `a_to_b` and the select inputs.
- R3: At a rising clock edge where `grab_b` of lane L is 1, the B-side register of lane L loads `b_in` bits [8L+7:8L]. This happens regardless of `lane_iso`, `a_to_b` and the select inputs.
- R4: When `lane_iso` of a lane is 1, that lane raises neither `a_drv` nor `b_drv`.
- R5: When `lane_iso` is 0, `a_to_b` = 1 sets `b_drv` and clears `a_drv`. `a_to_b` = 0 sets `a_drv` and clears `b_drv`.
- R6: While B is driven, `hold_to_b` = 0 puts the live `a_in` lane bits on `b_out` unchanged. `hold_to_b` = 1 puts the A-side register there.
- R7: While A is driven, `hold_to_a` = 0 puts the live `b_in` lane bits on `a_out` unchanged. `hold_to_a` = 1 puts the B-side register there.
- R8: `a_drv` and `b_drv` of the same lane are never 1 together.
- R9: Each lane obeys only its own control bits. Lane L controls bit L of every control vector and bus bits [8L+7:8L].
- R10: When a lane captures and drives the stored value of the same register, the output shows the old register value before the edge and the newly captured value after it. There is no combinational bypass.
- R11: The lane bits of an output whose drive enable is 0 read as zero.
- R12: A register whose capture enable is 0 at an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding registers |
| rst_n | input | 1 | Active-low reset, clears the holding registers |
| lane_iso | input | LANES | Per lane: 1 isolates both buses |
| a_to_b | input | LANES | Per lane: 1 drives B, 0 drives A |
| grab_a | input | LANES | Per lane: capture A data into the A-side register |
| grab_b | input | LANES | Per lane: capture B data into the B-side register |
| hold_to_b | input | LANES | Per lane: B output source, 0 live A, 1 A-side register |
| hold_to_a | input | LANES | Per lane: A output source, 0 live B, 1 B-side register |
| a_in | input | LANE_W*LANES | Data received from the A bus |
| a_out | output | LANE_W*LANES | Data to drive onto the A bus |
| a_drv | output | LANES | Per lane: A output enable |
| b_in | input | LANE_W*LANES | Data received from the B bus |
| b_out | output | LANE_W*LANES | Data to drive onto the B bus |
| b_drv | output | LANES | Per lane: B output enable |

## Verification
Some properties are checked on every cycle in every lane. Isolation suppresses both drive enables, and the two enables never rise together. An undriven output reads zero and a stored-mode output equals its register. A register loads exactly when its capture enable is high and otherwise holds.

Only the bench scenarios can show the rest. They show that data captured while a lane was isolated or facing the other way is later driven in stored mode. They show that the two lanes behave independently under mixed settings, and that a same-edge capture appears only after the edge. Reset, including a reset in the middle of operation, is checked by observing zeros in stored mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      RT_ISOLATE = 2'd0,
      RT_A_TO_B  = 2'd1,
      RT_B_TO_A  = 2'd2
   } route_e;

   function automatic route_e pick_route(input logic iso, input logic toward_b);
      if (iso)
         return RT_ISOLATE;
      else if (toward_b)
         return RT_A_TO_B;
      else
         return RT_B_TO_A;
   endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int W         = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("xcvr_store_reg: W must be at least 1");
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (load)
            q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (load)
            q <= d;
      end
   end

   // R2 R3
   load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

   // R12
   idle_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         iso,
   input  logic         toward_b,
   input  logic         src_reg_b,
   input  logic         src_reg_a,
   input  logic [W-1:0] a_live,
   input  logic [W-1:0] b_live,
   input  logic [W-1:0] a_held,
   input  logic [W-1:0] b_held,
   output logic [W-1:0] a_data,
   output logic         a_en,
   output logic [W-1:0] b_data,
   output logic         b_en
);

   route_e route;

   always_comb begin
      route  = pick_route(iso, toward_b);
      a_en   = 1'b0;
      b_en   = 1'b0;
      a_data = '0;
      b_data = '0;
      unique case (route)
         RT_A_TO_B: begin
            b_en   = 1'b1;
            b_data = src_reg_b ? a_held : a_live;
         end
         RT_B_TO_A: begin
            a_en   = 1'b1;
            a_data = src_reg_a ? b_held : b_live;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
   parameter int W         = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         iso,
   input  logic         toward_b,
   input  logic         cap_a,
   input  logic         cap_b,
   input  logic         src_reg_b,
   input  logic         src_reg_a,
   input  logic [W-1:0] a_live,
   input  logic [W-1:0] b_live,
   output logic [W-1:0] a_data,
   output logic         a_en,
   output logic [W-1:0] b_data,
   output logic         b_en
);

   logic [W-1:0] a_held;
   logic [W-1:0] b_held;

   xcvr_store_reg #(.W(W), .ASYNC_RST(ASYNC_RST)) u_reg_a (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_a),
      .d     (a_live),
      .q     (a_held)
   );

   xcvr_store_reg #(.W(W), .ASYNC_RST(ASYNC_RST)) u_reg_b (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_b),
      .d     (b_live),
      .q     (b_held)
   );

   xcvr_route #(.W(W)) u_route (
      .iso       (iso),
      .toward_b  (toward_b),
      .src_reg_b (src_reg_b),
      .src_reg_a (src_reg_a),
      .a_live    (a_live),
      .b_live    (b_live),
      .a_held    (a_held),
      .b_held    (b_held),
      .a_data    (a_data),
      .a_en      (a_en),
      .b_data    (b_data),
      .b_en      (b_en)
   );

   // R4
   iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> (!a_en && !b_en));

   // R8
   single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && b_en));

   // R6
   stored_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && src_reg_b) |-> (b_data == a_held));

   // R7
   stored_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && src_reg_a) |-> (a_data == b_held));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!a_en) |-> (a_data == '0)) and ((!b_en) |-> (b_data == '0)));

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
   parameter int LANE_W    = 8,
   parameter int LANES     = 2,
   parameter bit ASYNC_RST = 1'b1,
   localparam int BUS_W    = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_iso,
   input  logic [LANES-1:0] a_to_b,
   input  logic [LANES-1:0] grab_a,
   input  logic [LANES-1:0] grab_b,
   input  logic [LANES-1:0] hold_to_b,
   input  logic [LANES-1:0] hold_to_a,
   input  logic [BUS_W-1:0] a_in,
   output logic [BUS_W-1:0] a_out,
   output logic [LANES-1:0] a_drv,
   input  logic [BUS_W-1:0] b_in,
   output logic [BUS_W-1:0] b_out,
   output logic [LANES-1:0] b_drv
);

   if (LANE_W < 1) begin : g_bad_lane_w
      $error("bus_xcvr_reg: LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("bus_xcvr_reg: LANES must be at least 1");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      xcvr_lane #(.W(LANE_W), .ASYNC_RST(ASYNC_RST)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .iso       (lane_iso[l]),
         .toward_b  (a_to_b[l]),
         .cap_a     (grab_a[l]),
         .cap_b     (grab_b[l]),
         .src_reg_b (hold_to_b[l]),
         .src_reg_a (hold_to_a[l]),
         .a_live    (a_in[l*LANE_W +: LANE_W]),
         .b_live    (b_in[l*LANE_W +: LANE_W]),
         .a_data    (a_out[l*LANE_W +: LANE_W]),
         .a_en      (a_drv[l]),
         .b_data    (b_out[l*LANE_W +: LANE_W]),
         .b_en      (b_drv[l])
      );
   end

endmodule

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;

   localparam int LW = 8;
   localparam int NL = 2;
   localparam int BW = LW * NL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lane_iso = '1, a_to_b = '0, grab_a = '0, grab_b = '0;
   logic [NL-1:0] hold_to_b = '0, hold_to_a = '0;
   logic [BW-1:0] a_in = '0, b_in = '0;
   logic [BW-1:0] a_out, b_out;
   logic [NL-1:0] a_drv, b_drv;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [LW-1:0] mdl_a [NL];
   logic [LW-1:0] mdl_b [NL];

   always #2.5 clk = ~clk;

   bus_xcvr_reg #(.LANE_W(LW), .LANES(NL), .ASYNC_RST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .lane_iso(lane_iso), .a_to_b(a_to_b),
      .grab_a(grab_a), .grab_b(grab_b), .hold_to_b(hold_to_b), .hold_to_a(hold_to_a),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
   );

   typedef struct packed {
      logic [NL-1:0] iso;
      logic [NL-1:0] dir;
      logic [NL-1:0] ga;
      logic [NL-1:0] gb;
      logic [NL-1:0] hb;
      logic [NL-1:0] ha;
      logic [BW-1:0] a;
      logic [BW-1:0] b;
   } vec_t;

   // fields: iso, dir, grab_a, grab_b, hold_to_b, hold_to_a, a_in, b_in
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R2 R3 R4: capture both sides while isolated
      '{2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 16'h1234, 16'hABCD},
      // R6 R12: stored A to B, live A differs, no capture
      '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hFFFF, 16'h0000},
      // R7: stored B to A
      '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'h0000, 16'h0000},
      // R6: live A to B
      '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h5AA5, 16'h1111},
      // R7: live B to A
      '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h2222, 16'hC33C},
      // R9 R10: lanes opposite, same-edge capture with stored select
      '{2'b00, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 16'h9876, 16'h4321},
      // R9: lane 1 isolated, lane 0 live A to B
      '{2'b10, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h0F0F, 16'hF0F0},
      // R9: lane 0 isolated, lane 1 stored B to A
      '{2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'h3333, 16'h4444},
      // R2: capture A while driving A from live B
      '{2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 16'hDEAD, 16'hBEEF},
      // R2 R12: now show captured A in stored mode
      '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h0000, 16'h0000},
      // R6: all ones passes unchanged
      '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'hFFFF, 16'h0000},
      // R3 R10: capture B into register while driving it
      '{2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 16'h0000, 16'h55AA}
   };

   task automatic check(input string tag, input int lane, input logic [LW-1:0] got,
                        input logic [LW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s lane %0d: got %h expected %h", tag, lane, got, exp);
      end
   endtask

   task automatic compare(input string phase);
      for (int l = 0; l < NL; l++) begin
         logic [LW-1:0] ea, eb;
         logic eda, edb;
         string tag;
         eda = 1'b0; edb = 1'b0; ea = '0; eb = '0;
         if (lane_iso[l]) tag = "R4";
         else if (a_to_b[l]) begin
            edb = 1'b1;
            eb  = hold_to_b[l] ? mdl_a[l] : a_in[l*LW +: LW];
            tag = "R6";
         end else begin
            eda = 1'b1;
            ea  = hold_to_a[l] ? mdl_b[l] : b_in[l*LW +: LW];
            tag = "R7";
         end
         check({tag, " R5 R8 a_drv ", phase}, l, {7'd0, a_drv[l]}, {7'd0, eda});
         check({tag, " R5 R8 b_drv ", phase}, l, {7'd0, b_drv[l]}, {7'd0, edb});
         check({tag, " R9 R11 a_out ", phase}, l, a_out[l*LW +: LW], ea);
         check({tag, " R9 R11 b_out ", phase}, l, b_out[l*LW +: LW], eb);
      end
   endtask

   task automatic step(input vec_t v);
      lane_iso = v.iso; a_to_b = v.dir; grab_a = v.ga; grab_b = v.gb;
      hold_to_b = v.hb; hold_to_a = v.ha; a_in = v.a; b_in = v.b;
      #1 compare("before edge");
      @(posedge clk);
      for (int l = 0; l < NL; l++) begin
         if (rst_n && grab_a[l]) mdl_a[l] = a_in[l*LW +: LW];
         if (rst_n && grab_b[l]) mdl_b[l] = b_in[l*LW +: LW];
      end
      #1 compare("after edge R10");
      @(negedge clk);
   endtask

   task automatic clear_model();
      for (int l = 0; l < NL; l++) begin
         mdl_a[l] = '0;
         mdl_b[l] = '0;
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      clear_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: stored mode right after reset shows zero in both directions
      step('{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h7777, 16'h8888});
      check("R1 stored B after reset", 0, b_out[7:0], 8'h00);
      step('{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'h7777, 16'h8888});
      check("R1 stored A after reset", 1, a_out[15:8], 8'h00);

      for (int i = 0; i < NV; i++) step(VECS[i]);

      // R1: reset in mid operation clears captured values
      step('{2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 16'hA5A5, 16'h5A5A});
      rst_n = 1'b0;
      grab_a = '0; grab_b = '0;
      @(posedge clk);
      #1 clear_model();
      @(negedge clk);
      rst_n = 1'b1;
      step('{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hFFFF, 16'hFFFF});
      check("R1 B after mid reset", 1, b_out[15:8], 8'h00);
      step('{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'hFFFF, 16'hFFFF});
      check("R1 A after mid reset", 0, a_out[7:0], 8'h00);

      // R12: hold across several idle edges, then read back
      step('{2'b11, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 16'h00C8, 16'h0000});
      for (int k = 0; k < 4; k++)
         step('{2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF});
      step('{2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 16'hFFFF, 16'h0000});
      check("R12 held A value", 0, b_out[7:0], 8'hC8);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule